// File: doc/BRIEF.md
# Control Store Program Counter

This block supplies the instruction address for a small microcoded disk sequencer. It combines three pieces of state. A holding register keeps the last start address written by the host. An address counter serves as the program counter while the sequencer runs, and the host can read it at any time. A loop register holds the jump-back target. Instruction decode and the control store memory sit outside the block. The block receives the current instruction's control flags on an end-of-instruction strobe, together with the live error flags and the sector count, and decides which address comes next.

The host can start the sequencer by writing a start address, or by writing a sector count after a normal stop. While the sequencer is halted, the counter points at the instruction where the halt happened. Writes to any of the control-store window registers step the counter forward, so the host can walk through the store one word at a time. A failing instruction puts the block into an error halt. Only a new start write clears that halt.

Top module: `cspc_top`

## Requirements
- R1: A host start write (`start_wr`) loads `start_wdata` into the holding register and the address counter. `pc_o` shows the new value in the cycle after the write. This write takes precedence over every other update.
- R2: Reset sets the counter to 0 and the block to halted (`running_o`=0). Reset leaves the holding register and the loop register unchanged.
- R3: A write to any bit of `win_wr` increments the counter by one, wrapping from 31 to 0. This applies while halted, and while running in a cycle without `instr_end`.
- R4: At the end of a running instruction whose jump flag is set, the counter loads the loop register. A loop write in that same cycle takes effect only for later jumps.
- R5: At the end of a running instruction with the retry flag set, the counter loads the loop register when any bit of `err_flags` is 1 (bit 0 checksum, bit 1 compare, bit 2 sync). The sequencer keeps running even if the fail flag is also set. Retry with no error flag set has no effect.
- R6: At the end of a running instruction with the fail flag set, no retry, and an error flag active, the block enters an error halt and the counter holds. In this halt a sector count write does not restart the sequencer. A start write clears the halt, and execution resumes if `sec_cnt` is nonzero.
- R7: At the end of a running instruction with the stop flag set and `sec_cnt`=0, the block halts and the counter holds. A later `sec_wr` with a nonzero `sec_cnt` restarts execution at the holding register value. A `sec_wr` with zero has no effect. A stop flag with a nonzero count does not halt.
- R8: Any other end of a running instruction increments the counter, wrapping from 31 to 0. `instr_end` while halted has no effect.
- R9: When the updates collide, the start write comes first, then the `instr_end` update of a running sequencer, then the window increment.
- R10: A start write while halted with `sec_cnt`=0 loads the counter and leaves the block halted. A start write while running keeps the block running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_wr | input | 1 | Host write strobe for the start address |
| start_wdata | input | ADDR_W | Start address written by the host |
| loop_wr | input | 1 | Host write strobe for the loop register |
| loop_wdata | input | ADDR_W | Loop address written by the host |
| win_wr | input | NWIN | One strobe per control-store window register |
| instr_end | input | 1 | End of the current instruction |
| instr_jump | input | 1 | Current instruction jumps to the loop address |
| instr_retry | input | 1 | Current instruction retries on error |
| instr_stop | input | 1 | Current instruction ends the program |
| instr_fail | input | 1 | Current instruction halts on error |
| err_flags | input | NERR | Error flags: bit 0 checksum, bit 1 compare, bit 2 sync |
| sec_wr | input | 1 | Host wrote the sector count this cycle |
| sec_cnt | input | CNT_W | Current sector count |
| pc_o | output | ADDR_W | Address counter, readable by the host |
| running_o | output | 1 | 1 while the sequencer runs |

## Verification
The hardest cases to reach are the two halt kinds. Each one must be told apart only by how it responds to later host writes. The stimulus first enters an error halt through a failing instruction. It then issues a sector count write and shows that no restart follows, and only after that issues the clearing start write. Separately, the stimulus stops on a zero count and restarts through a count write. It places a reset and several start writes beforehand, so the restart address proves that the holding register survived the reset. Collision cycles drive a start write, an `instr_end` and a window write together to expose the precedence order.

// File: rtl/cspc_pkg.sv
package cspc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_ERR  = 2'd2
  } run_st_e;

  typedef enum logic [2:0] {
    NX_KEEP = 3'd0,
    NX_HOST = 3'd1,
    NX_LOOP = 3'd2,
    NX_HOLD = 3'd3,
    NX_INC  = 3'd4
  } nx_src_e;
endpackage

// File: rtl/cspc_regs.sv
module cspc_regs #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              start_wr,
  input  logic [ADDR_W-1:0] start_wdata,
  input  logic              loop_wr,
  input  logic [ADDR_W-1:0] loop_wdata,
  output logic [ADDR_W-1:0] hold_q,
  output logic [ADDR_W-1:0] loop_q
);
  // Neither register responds to reset.
  always_ff @(posedge clk) begin
    if (start_wr) hold_q <= start_wdata;
    if (loop_wr)  loop_q <= loop_wdata;
  end

  assert_loop_capture_R4: assert property (@(posedge clk)
    loop_wr |=> loop_q == $past(loop_wdata));
endmodule

// File: rtl/cspc_ctrl.sv
module cspc_ctrl
  import cspc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start_wr,
  input  logic    win_any,
  input  logic    instr_end,
  input  logic    instr_jump,
  input  logic    instr_retry,
  input  logic    instr_stop,
  input  logic    instr_fail,
  input  logic    err_any,
  input  logic    sec_wr,
  input  logic    sec_nz,
  output nx_src_e nx_src,
  output run_st_e state_q,
  output logic    run_q
);
  run_st_e st_n;

  always_comb begin
    nx_src = NX_KEEP;
    st_n   = state_q;
    if (start_wr) begin
      nx_src = NX_HOST;
      if (state_q != ST_RUN && sec_nz) st_n = ST_RUN;
      else if (state_q == ST_ERR)      st_n = ST_IDLE;
    end else if (state_q == ST_RUN && instr_end) begin
      if (instr_retry && err_any) begin
        nx_src = NX_LOOP;
      end else if (instr_fail && err_any) begin
        st_n = ST_ERR;
      end else if (instr_stop && !sec_nz) begin
        st_n = ST_IDLE;
      end else if (instr_jump) begin
        nx_src = NX_LOOP;
      end else begin
        nx_src = NX_INC;
      end
    end else if (state_q == ST_IDLE && sec_wr && sec_nz) begin
      nx_src = NX_HOLD;
      st_n   = ST_RUN;
    end else if (win_any) begin
      nx_src = NX_INC;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      run_q   <= 1'b0;
    end else begin
      state_q <= st_n;
      run_q   <= (st_n == ST_RUN);
    end
  end

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERR && !start_wr) |=> state_q == ST_ERR);

  assert_stop_halts_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && instr_end && instr_stop && !sec_nz && !start_wr &&
     !((instr_retry || instr_fail) && err_any)) |=> state_q == ST_IDLE);

  assert_fail_halts_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && instr_end && instr_fail && !instr_retry && err_any &&
     !start_wr) |=> (state_q == ST_ERR && !run_q));
endmodule

// File: rtl/cspc_counter.sv
module cspc_counter
  import cspc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  nx_src_e           nx_src,
  input  logic [ADDR_W-1:0] host_d,
  input  logic [ADDR_W-1:0] loop_d,
  input  logic [ADDR_W-1:0] hold_d,
  output logic [ADDR_W-1:0] pc_q
);
  localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else begin
      case (nx_src)
        NX_HOST: pc_q <= host_d;
        NX_LOOP: pc_q <= loop_d;
        NX_HOLD: pc_q <= hold_d;
        NX_INC:  pc_q <= pc_q + PC_ONE;
        default: pc_q <= pc_q;
      endcase
    end
  end

  assert_restart_from_hold_R7: assert property (@(posedge clk) disable iff (rst)
    nx_src == NX_HOLD |=> pc_q == $past(hold_d));
endmodule

// File: rtl/cspc_top.sv
module cspc_top
  import cspc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int NWIN   = 4,
  parameter int NERR   = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_wr,
  input  logic [ADDR_W-1:0] start_wdata,
  input  logic              loop_wr,
  input  logic [ADDR_W-1:0] loop_wdata,
  input  logic [NWIN-1:0]   win_wr,
  input  logic              instr_end,
  input  logic              instr_jump,
  input  logic              instr_retry,
  input  logic              instr_stop,
  input  logic              instr_fail,
  input  logic [NERR-1:0]   err_flags,
  input  logic              sec_wr,
  input  logic [CNT_W-1:0]  sec_cnt,
  output logic [ADDR_W-1:0] pc_o,
  output logic              running_o
);
  logic [ADDR_W-1:0] hold_q;
  logic [ADDR_W-1:0] loop_q;
  nx_src_e           nx_src;
  run_st_e           state_q;
  logic              win_any;
  logic              err_any;
  logic              sec_nz;

  assign win_any = |win_wr;
  assign err_any = |err_flags;
  assign sec_nz  = |sec_cnt;

  cspc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .start_wr(start_wr), .start_wdata(start_wdata),
    .loop_wr(loop_wr), .loop_wdata(loop_wdata),
    .hold_q(hold_q), .loop_q(loop_q)
  );

  cspc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start_wr(start_wr), .win_any(win_any),
    .instr_end(instr_end), .instr_jump(instr_jump), .instr_retry(instr_retry),
    .instr_stop(instr_stop), .instr_fail(instr_fail), .err_any(err_any),
    .sec_wr(sec_wr), .sec_nz(sec_nz),
    .nx_src(nx_src), .state_q(state_q), .run_q(running_o)
  );

  cspc_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk(clk), .rst(rst), .nx_src(nx_src),
    .host_d(start_wdata), .loop_d(loop_q), .hold_d(hold_q),
    .pc_q(pc_o)
  );

  assert_host_load_R1: assert property (@(posedge clk) disable iff (rst)
    start_wr |=> pc_o == $past(start_wdata));

  assert_window_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!running_o && win_any && !start_wr && !sec_wr)
      |=> pc_o == ADDR_W'($past(pc_o) + 1'b1));

  assert_jump_loads_R4: assert property (@(posedge clk) disable iff (rst)
    (running_o && instr_end && instr_jump && !start_wr && !instr_stop &&
     !((instr_retry || instr_fail) && err_any)) |=> pc_o == $past(loop_q));

  assert_retry_loads_R5: assert property (@(posedge clk) disable iff (rst)
    (running_o && instr_end && instr_retry && err_any && !start_wr)
      |=> (pc_o == $past(loop_q) && running_o));

  assert_halted_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!running_o && !start_wr && !win_any && !sec_wr) |=> $stable(pc_o));

  assert_halted_dup_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_RUN) |-> !running_o);
endmodule

// File: tb/tb_cspc_top.sv
module tb_cspc_top;
  localparam int AW = 5;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_wr = 0, loop_wr = 0, instr_end = 0, jmp = 0, rty = 0, stp = 0, fl = 0, sec_wr = 0;
  logic [AW-1:0] start_d = '0, loop_d = '0;
  logic [3:0] win = '0;
  logic [2:0] err = '0;
  logic [7:0] sec = '0;
  logic [AW-1:0] pc_o;
  logic running_o;

  int total = 0, bad = 0;
  logic [AW:0] exp_q[$];
  string tag_q[$];
  // model: 0 idle, 1 run, 2 error halt
  int m_st = 0;
  logic [AW-1:0] m_pc = '0, m_hold = '0, m_loop = '0;

  always #2.5 clk = ~clk;

  cspc_top dut (
    .clk(clk), .rst(rst), .start_wr(start_wr), .start_wdata(start_d),
    .loop_wr(loop_wr), .loop_wdata(loop_d), .win_wr(win),
    .instr_end(instr_end), .instr_jump(jmp), .instr_retry(rty),
    .instr_stop(stp), .instr_fail(fl), .err_flags(err),
    .sec_wr(sec_wr), .sec_cnt(sec), .pc_o(pc_o), .running_o(running_o)
  );

  task automatic check(string tag, logic [AW:0] act, logic [AW:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: pc/run actual=%0d/%0d expected=%0d/%0d",
               tag, act[AW:1], act[0], exp[AW:1], exp[0]);
    end
  endtask

  // monitor: pops expected items after each edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) check(tag_q.pop_front(), {pc_o, running_o}, exp_q.pop_front());
  end

  task automatic go();
    @(negedge clk);
    start_wr = 0; loop_wr = 0; win = '0; instr_end = 0; jmp = 0;
    rty = 0; stp = 0; fl = 0; err = '0; sec_wr = 0;
  endtask

  // driver: computes expectation from the requirements, then pushes it
  task automatic tick(string tag);
    if (start_wr) begin
      m_hold = start_d; m_pc = start_d;
      if (m_st != 1 && sec != 0) m_st = 1;
      else if (m_st == 2) m_st = 0;
    end else if (m_st == 1 && instr_end) begin
      if (rty && |err) m_pc = m_loop;
      else if (fl && |err) m_st = 2;
      else if (stp && sec == 0) m_st = 0;
      else if (jmp) m_pc = m_loop;
      else m_pc = m_pc + 1'b1;
    end else if (m_st == 0 && sec_wr && sec != 0) begin
      m_pc = m_hold; m_st = 1;
    end else if (|win) begin
      m_pc = m_pc + 1'b1;
    end
    if (loop_wr) m_loop = loop_d;
    @(posedge clk);
    exp_q.push_back({m_pc, m_st == 1});
    tag_q.push_back(tag);
  endtask

  task automatic do_reset();
    go(); rst = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 0;
    m_st = 0; m_pc = '0;
    check("R2 reset", {pc_o, running_o}, {5'd0, 1'b0});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    go(); loop_wr = 1; loop_d = 5'd7; tick("R4 loop write");
    go(); start_wr = 1; start_d = 5'd9; tick("R1 R10 start while halted");
    for (int i = 0; i < 4; i++) begin
      go(); win = 4'b0001 << i; tick("R3 window step");
    end
    go(); start_wr = 1; start_d = 5'd31; tick("R1 start");
    go(); win = 4'b1000; tick("R3 window wrap");
    do_reset();
    go(); sec = 8'd3; sec_wr = 1; tick("R7 R2 restart from retained hold");
    go(); instr_end = 1; tick("R8 increment wrap");
    go(); instr_end = 1; tick("R8 increment");
    go(); instr_end = 1; jmp = 1; tick("R4 R2 jump to retained loop");
    go(); instr_end = 1; rty = 1; tick("R5 retry without error");
    go(); instr_end = 1; rty = 1; err = 3'b001; tick("R5 retry checksum");
    go(); instr_end = 1; rty = 1; err = 3'b100; tick("R5 retry sync");
    go(); instr_end = 1; rty = 1; fl = 1; err = 3'b010; tick("R5 retry beats fail");
    go(); instr_end = 1; stp = 1; tick("R7 stop with count");
    go(); start_wr = 1; start_d = 5'd20; instr_end = 1; jmp = 1; win = 4'b0010;
    tick("R9 start write first");
    go(); instr_end = 1; win = 4'b0100; tick("R9 instr beats window");
    go(); win = 4'b0001; tick("R3 window while running");
    go(); instr_end = 1; fl = 1; err = 3'b010; tick("R6 fail halt");
    go(); instr_end = 1; tick("R8 end ignored while halted");
    go(); win = 4'b0010; tick("R3 window in error halt");
    go(); sec_wr = 1; tick("R6 count write no restart");
    go(); start_wr = 1; start_d = 5'd4; tick("R6 start clears and resumes");
    go(); sec = 8'd0; instr_end = 1; stp = 1; tick("R7 stop halt");
    go(); sec_wr = 1; tick("R7 zero count no restart");
    go(); start_wr = 1; start_d = 5'd10; tick("R10 start halted zero count");
    go(); sec = 8'd2; sec_wr = 1; tick("R7 restart");
    go(); loop_wr = 1; loop_d = 5'd3; instr_end = 1; jmp = 1; tick("R4 old loop used");
    go(); instr_end = 1; jmp = 1; tick("R4 new loop");
    go(); start_wr = 1; start_d = 5'd12; tick("R10 start while running");
    go(); instr_end = 1; fl = 1; err = 3'b001; tick("R6 fail halt again");
    go(); sec = 8'd0; start_wr = 1; start_d = 5'd1; tick("R6 clear with zero count");
    go(); sec = 8'd5; sec_wr = 1; tick("R7 restart after cleared error");
    go();
    @(negedge clk); @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule